// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block connects an I2C bus to a two-byte configuration store that sits at bus register addresses 0xFF and 0xFE. A fast system clock oversamples SCL and SDA. Each line passes through a synchronizer and a run-length filter, so short spikes never reach the protocol logic. The protocol engine detects START, repeated START and STOP and compares the first byte with a fixed 7-bit device address. It then serves byte writes, page writes, current-address reads, random reads (a dummy write followed by a read) and sequential reads. SDA is pulled low through an output-enable and is never driven high.

The register pointer keeps only its low nibble, and the upper nibble always reads as 1111. The pointer holds the location after the last one accessed. It steps upward, except that it steps from 0xFF back to 0xFE. The two stored bytes appear on parallel outputs for the clock logic that consumes them. Bits that are not implemented read as zero.

Top module: `i2c_cfg_slave`

## Requirements
- R1: While reset is high, and directly after it, `cfg_hi` is 0x8F, `cfg_lo` is 0xF8, `sda_oe` is 0, and the pointer selects 0xFF. A current-address read made first after reset therefore returns 0x8F.
- R2: The block acknowledges only the device address 1010110 (write byte 0xAC, read byte 0xAD; bit 0 is R/W, 1 = read). For any other address it leaves the acknowledge bit high and ignores every byte until the next START.
- R3: In a byte write, the block sends an ACK after the device address, after the register address and after the data. The data is stored at {1111, low nibble of the register address}. At 0xFF only bits 7 and 3..0 are stored. At 0xFE only bits 7..3 are stored. Bits that are not stored read 0. The configuration outputs change only on such writes.
- R4: In a page write, each further data byte goes to the next pointer location and is acknowledged. The pointer steps from 0xFF to 0xFE, so the sequence FE, FF, FE is written in that order.
- R5: A random read returns the byte at the given register address, MSB first. The sequence is a dummy write of the register address, a repeated START, 0xAD, the data, then NACK and STOP.
- R6: A current-address read returns the byte at the location after the last one accessed, by read or write. After an access to 0xFF it returns the byte at 0xFE.
- R7: In a sequential read, the block supplies the next location's byte each time the master sends ACK. After a NACK it releases SDA and goes idle.
- R8: A register address whose low nibble is not 0xE or 0xF reads 0x00. A write to it is acknowledged and leaves both stored bytes unchanged.
- R9: A pulse shorter than FILT_HOLD system clocks (3 clocks, 60 ns, at 50 MHz) on SCL or on SDA has no effect. Such a pulse creates no extra bit and no false START or STOP.
- R10: `sda_oe` changes only while SCL is low.
- R11: A repeated START during a transfer restarts device-address reception. A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_hi | output | 8 | Stored byte at address 0xFF |
| cfg_lo | output | 8 | Stored byte at address 0xFE |

## Verification
The hardest conditions to reach from the ports are the two spike cases. One is an SCL pulse inside the low half of a bit. The other is an SDA dip while SCL is high, which without filtering would look like a START. The bench injects both as two-clock pulses inside a single data byte. It then checks through the configuration output that the byte was stored without shifting. The pointer wrap from 0xFF to 0xFE is also reached only through chains of accesses. Page writes, chained current-address reads and a three-byte sequential read starting at 0xFF expose it.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } fsm_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA
    } rx_phase_e;

    // Conditions seen on the filtered bus in one system clock
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    // Requests from the protocol engine to the register bank
    typedef struct packed {
        logic       load;
        logic [3:0] load_val;
        logic       wr;
        logic [7:0] wdata;
        logic       take;
    } reg_req_t;

    localparam logic [3:0] PTR_UPPER = 4'hF;
    localparam logic [3:0] LOC_LO    = 4'hE;
    localparam logic [3:0] LOC_HI    = 4'hF;

    // Pointer step: upward, except the top location folds back to 0xE
    function automatic logic [3:0] ptr_step(input logic [3:0] p);
        return (p == LOC_HI) ? LOC_LO : p + 4'd1;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(HOLD + 1);

    logic sync_out;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= din;
            end
            assign sync_out = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '1;
                else     s_q <= {s_q[SYNC_STAGES-2:0], din};
            end
            assign sync_out = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // The output follows the input only after HOLD equal samples in a row
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b1;
            run_q <= '0;
        end else if (sync_out != dout) begin
            if (run_q == CW'(HOLD - 1)) begin
                dout  <= sync_out;
                run_q <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
        ev.sda      = sda;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter logic [7:0] HI_MASK = 8'h8F,
    parameter logic [7:0] LO_MASK = 8'hF8,
    parameter logic [7:0] HI_RST  = 8'h8F,
    parameter logic [7:0] LO_RST  = 8'hF8
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_req_t   req,
    output logic [7:0] rdata,
    output logic [3:0] ptr,
    output logic [7:0] cfg_hi,
    output logic [7:0] cfg_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= LOC_HI;
        end else if (req.load) begin
            ptr <= req.load_val;
        end else if (req.wr || req.take) begin
            ptr <= ptr_step(ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_hi <= HI_RST & HI_MASK;
            cfg_lo <= LO_RST & LO_MASK;
        end else if (req.wr) begin
            if (ptr == LOC_HI) cfg_hi <= req.wdata & HI_MASK;
            if (ptr == LOC_LO) cfg_lo <= req.wdata & LO_MASK;
        end
    end

    always_comb begin
        case (ptr)
            LOC_HI:  rdata = cfg_hi;
            LOC_LO:  rdata = cfg_lo;
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010110
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rdata,
    output reg_req_t   req,
    output logic       sda_oe,
    output fsm_state_e state
);
    rx_phase_e  phase;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [3:0] cnt;
    logic       go_read;
    logic       mack_ok;

    logic byte_done;
    logic load_tx;
    logic quiet;

    assign quiet     = ~ev.start & ~ev.stop;
    assign byte_done = quiet && (state == ST_RX) && ev.scl_fall && (cnt == 4'd8);
    assign load_tx   = quiet && ev.scl_fall &&
                       (((state == ST_ACK) && go_read) ||
                        ((state == ST_MACK) && mack_ok));

    always_comb begin
        req.load     = byte_done && (phase == PH_REG);
        req.load_val = shreg[3:0];
        req.wr       = byte_done && (phase == PH_DATA);
        req.wdata    = shreg;
        req.take     = load_tx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            shreg   <= '0;
            txreg   <= '0;
            cnt     <= '0;
            go_read <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_RX;
            phase  <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.scl_rise && cnt != 4'd8) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        if (phase == PH_DEV) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                go_read <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            sda_oe  <= 1'b1;
                            state   <= ST_ACK;
                            go_read <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (go_read) begin
                            state  <= ST_TX;
                            txreg  <= rdata;
                            sda_oe <= ~rdata[7];
                        end else begin
                            state  <= ST_RX;
                            phase  <= (phase == PH_DEV) ? PH_REG : PH_DATA;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[6:0], 1'b0};
                            sda_oe <= ~txreg[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            state  <= ST_TX;
                            cnt    <= '0;
                            txreg  <= rdata;
                            sda_oe <= ~rdata[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010110,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_HOLD   = 3,
    parameter logic [7:0] HI_MASK     = 8'h8F,
    parameter logic [7:0] LO_MASK     = 8'hF8,
    parameter logic [7:0] HI_RST      = 8'h8F,
    parameter logic [7:0] LO_RST      = 8'hF8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] cfg_hi,
    output logic [7:0] cfg_lo
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_filt
            i2c_glitch_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .HOLD       (FILT_HOLD)
            ) u_filt (
                .clk (clk),
                .rst (rst),
                .din (raw_lines[g]),
                .dout(clean_lines[g])
            );
        end
    endgenerate

    bus_ev_t    ev_w;
    reg_req_t   req_w;
    logic [7:0] rdata_w;
    logic [3:0] ptr_w;
    fsm_state_e state_w;

    i2c_bus_events u_ev (
        .clk(clk),
        .rst(rst),
        .scl(clean_lines[0]),
        .sda(clean_lines[1]),
        .ev (ev_w)
    );

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev_w),
        .rdata (rdata_w),
        .req   (req_w),
        .sda_oe(sda_oe),
        .state (state_w)
    );

    i2c_reg_bank #(
        .HI_MASK(HI_MASK),
        .LO_MASK(LO_MASK),
        .HI_RST (HI_RST),
        .LO_RST (LO_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req_w),
        .rdata (rdata_w),
        .ptr   (ptr_w),
        .cfg_hi(cfg_hi),
        .cfg_lo(cfg_lo)
    );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import i2c_cfg_pkg::*;
#(
    parameter logic [7:0] HI_MASK = 8'h8F,
    parameter logic [7:0] LO_MASK = 8'hF8,
    parameter logic [7:0] HI_RST  = 8'h8F,
    parameter logic [7:0] LO_RST  = 8'hF8
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [7:0] cfg_hi,
    input logic [7:0] cfg_lo,
    input logic [3:0] ptr,
    input logic       ptr_load,
    input logic       wr_en,
    input fsm_state_e state
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cfg_hi == (HI_RST & HI_MASK) && cfg_lo == (LO_RST & LO_MASK)
                 && !sda_oe && ptr == 4'hF));

    assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    assert_hi_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_hi & ~HI_MASK) == 8'h00);

    assert_lo_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_lo & ~LO_MASK) == 8'h00);

    assert_cfg_only_on_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_hi) || !$stable(cfg_lo)) |-> $past(wr_en));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(ptr) == 4'hF && !$past(ptr_load) && !$stable(ptr)) |-> ptr == 4'hE);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
    .HI_MASK(HI_MASK),
    .LO_MASK(LO_MASK),
    .HI_RST (HI_RST),
    .LO_RST (LO_RST)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .cfg_hi  (cfg_hi),
    .cfg_lo  (cfg_lo),
    .ptr     (ptr_w),
    .ptr_load(req_w.load),
    .wr_en   (req_w.wr),
    .state   (state_w)
);

// File: tb/sim_i2c_cfg_slave.sv
`timescale 1ns/1ps
module sim_i2c_cfg_slave;
    localparam int Q    = 25;
    localparam int NVEC = 13;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_CR = 2'd2;

    // {op, register address, data, expected}
    localparam logic [25:0] VEC [NVEC] = '{
        {OP_CR, 8'h00, 8'h00, 8'h8F},  // R1 R6 first current read -> FF
        {OP_CR, 8'h00, 8'h00, 8'hF8},  // R6 wrap FF -> FE
        {OP_WR, 8'hFF, 8'h05, 8'h05},  // R3
        {OP_RD, 8'hFF, 8'h00, 8'h05},  // R5
        {OP_WR, 8'hFE, 8'h37, 8'h30},  // R3 mask
        {OP_RD, 8'hFE, 8'h00, 8'h30},  // R5
        {OP_CR, 8'h00, 8'h00, 8'h05},  // R6 FE -> FF
        {OP_CR, 8'h00, 8'h00, 8'h30},  // R6 FF -> FE
        {OP_WR, 8'hF3, 8'hAA, 8'h05},  // R8 discarded, cfg_hi unchanged
        {OP_RD, 8'hF3, 8'h00, 8'h00},  // R8
        {OP_CR, 8'h00, 8'h00, 8'h00},  // R8 R6 F4
        {OP_WR, 8'hFF, 8'h8A, 8'h8A},  // R3
        {OP_RD, 8'hFF, 8'h00, 8'h8A}   // R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [7:0] cfg_hi, cfg_lo;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_cfg_slave u0 (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_m),
        .sda_i (sda_line),
        .sda_oe(sda_oe),
        .cfg_hi(cfg_hi),
        .cfg_lo(cfg_lo)
    );

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b1; wc(Q);
    endtask

    // gscl / gsda: bit index receiving a two-clock spike, -1 for none
    task automatic wbyte(input logic [7:0] b, input int gscl, input int gsda,
                         output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (gscl == i) begin
                wc(12); scl_m = 1'b1; wc(2); scl_m = 1'b0; wc(Q - 14);
            end else begin
                wc(Q);
            end
            scl_m = 1'b1;
            if (gsda == i) begin
                wc(Q); sda_m = 1'b0; wc(2); sda_m = 1'b1; wc(Q - 2);
            end else begin
                wc(2 * Q);
            end
            scl_m = 1'b0; wc(Q);
        end
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b1; wc(Q);
        ack = sda_line; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wc(Q); scl_m = 1'b1;
            wc(Q); d[i] = sda_line;
            wc(Q); scl_m = 1'b0;
            wc(Q);
        end
        sda_m = nack; wc(Q);
        scl_m = 1'b1; wc(2 * Q);
        scl_m = 1'b0; wc(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
        logic k0, k1, k2;
        bus_start();
        wbyte(8'hAC, -1, -1, k0);
        wbyte(a, -1, -1, k1);
        wbyte(d, -1, -1, k2);
        bus_stop();
        check({k0, k1, k2} == 3'b000, req, {5'b0, k0, k1, k2}, 8'h00);
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        wbyte(8'hAC, -1, -1, k);
        wbyte(a, -1, -1, k);
        bus_start();
        wbyte(8'hAD, -1, -1, k);
        rbyte(1'b1, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic k;
        bus_start();
        wbyte(8'hAD, -1, -1, k);
        rbyte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic k, k1, k2;
        logic [1:0] op;
        logic [7:0] va, vd, ve;

        wc(5);
        // R1: reset state at the ports
        check(cfg_hi == 8'h8F, "R1 cfg_hi reset", cfg_hi, 8'h8F);
        check(cfg_lo == 8'hF8, "R1 cfg_lo reset", cfg_lo, 8'hF8);
        check(sda_oe == 1'b0, "R1 sda released", {7'b0, sda_oe}, 8'h00);
        rst = 1'b0;
        wc(20);

        for (int i = 0; i < NVEC; i++) begin
            {op, va, vd, ve} = VEC[i];
            case (op)
                OP_WR: begin
                    do_write(va, vd, "R3 write acks");
                    if (va[3:0] == 4'hE)
                        check(cfg_lo == ve, "R3 cfg_lo after write", cfg_lo, ve);
                    else
                        check(cfg_hi == ve, "R3/R8 cfg_hi after write", cfg_hi, ve);
                end
                OP_RD: begin
                    rand_read(va, d);
                    check(d == ve, "R5 random read", d, ve);
                end
                default: begin
                    cur_read(d);
                    check(d == ve, "R6 current read", d, ve);
                end
            endcase
        end

        // R4: page write FE, FF, FE
        bus_start();
        wbyte(8'hAC, -1, -1, k);
        wbyte(8'hFE, -1, -1, k);
        wbyte(8'h48, -1, -1, k);
        wbyte(8'h8B, -1, -1, k1);
        wbyte(8'h17, -1, -1, k2);
        bus_stop();
        check({k, k1, k2} == 3'b000, "R4 page acks", {5'b0, k, k1, k2}, 8'h00);
        check(cfg_hi == 8'h8B, "R4 page second byte", cfg_hi, 8'h8B);
        check(cfg_lo == 8'h10, "R4 page wrapped third byte", cfg_lo, 8'h10);

        // R6: last accessed FE -> current read returns FF
        cur_read(d);
        check(d == 8'h8B, "R6 after page write", d, 8'h8B);

        // R7: sequential read FF, FE, FF
        bus_start();
        wbyte(8'hAC, -1, -1, k);
        wbyte(8'hFF, -1, -1, k);
        bus_start();                    // R11 repeated START
        wbyte(8'hAD, -1, -1, k);
        check(k == 1'b0, "R11 address after repeated START", {7'b0, k}, 8'h00);
        rbyte(1'b0, d);
        check(d == 8'h8B, "R7 seq byte 0", d, 8'h8B);
        rbyte(1'b0, d);
        check(d == 8'h10, "R7 seq byte 1", d, 8'h10);
        rbyte(1'b1, d);
        check(d == 8'h8B, "R7 seq byte 2", d, 8'h8B);
        check(sda_oe == 1'b0, "R7 released after NACK", {7'b0, sda_oe}, 8'h00);
        bus_stop();
        check(sda_oe == 1'b0, "R11 idle after STOP", {7'b0, sda_oe}, 8'h00);

        // R2: foreign address, following bytes ignored
        bus_start();
        wbyte(8'hA0, -1, -1, k);
        check(k == 1'b1, "R2 foreign address NACK", {7'b0, k}, 8'h01);
        wbyte(8'hFE, -1, -1, k1);
        wbyte(8'h55, -1, -1, k2);
        bus_stop();
        check({k1, k2} == 2'b11, "R2 ignored bytes NACK", {6'b0, k1, k2}, 8'h03);
        check(cfg_lo == 8'h10, "R2 cfg_lo untouched", cfg_lo, 8'h10);
        bus_start();
        wbyte(8'hAF, -1, -1, k);
        bus_stop();
        check(k == 1'b1, "R2 foreign read address NACK", {7'b0, k}, 8'h01);

        // R9: SCL spike in bit 2, SDA dip at bit 7 while SCL high
        bus_start();
        wbyte(8'hAC, -1, -1, k);
        wbyte(8'hFE, -1, -1, k);
        wbyte(8'hA8, 2, 7, k1);
        bus_stop();
        check(k1 == 1'b0, "R9 ack with spikes", {7'b0, k1}, 8'h00);
        check(cfg_lo == 8'hA8, "R9 byte intact after spikes", cfg_lo, 8'hA8);

        // R10: master sees released line after each transfer
        check(sda_line == 1'b1, "R10 line high when idle", {7'b0, sda_line}, 8'h01);

        // R1: reset again restores defaults and pointer
        rst = 1'b1; wc(3);
        rst = 1'b0; wc(5);
        check(cfg_hi == 8'h8F && cfg_lo == 8'hF8, "R1 defaults after reset",
              cfg_lo, 8'hF8);
        cur_read(d);
        check(d == 8'h8F, "R1 pointer at FF after reset", d, 8'h8F);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule